// File: doc/BRIEF.md
# Multi-Mode Bus Transfer Sequencer

This block is a bus master that writes a block of words from a local source onto a shared system bus. The local side supplies a start address, a word count, a cycle-kind code and a width selection, then pulses `start`. From there the sequencer produces every bus phase by itself. It takes one word from `wdata` for each accepted data beat and signals this on `take`. When the last word has been accepted it pulses `done`.

The sequencer can run four kinds of bus cycle:
- **Basic cycles** drive a fresh address for every word, followed by a data phase of the same length.
- **Matched-memory cycles** use shorter phases. An optional wait phase can sit between the address and the data.
- **Streaming bursts** put the address on the bus once. After that they run short back-to-back data beats while an internal counter advances the implied address.
- **64-bit streaming** reuses the address lines to carry the upper half of each beat. A faster 64-bit variant shortens the beat again.

Streaming is used only when the target reports that it can stream. The 64-bit forms also need the dual-path configuration. When these conditions are not met, the burst falls back to basic cycles. Each data phase or beat holds on its last tick until the target raises `rdy`. Phase lengths are parameters counted in clocks, and the internal address counter is visible on `dbg_addr`.

Top module: `bus_xfer_seq`

## Requirements
- R1: Mode code 0 (and codes 6 and 7) gives basic cycles: for each word, `adr_strobe` is high for BASIC_TICKS clocks with the word's own byte address on `bus_adr`, then `dat_strobe` is high for BASIC_TICKS clocks; with `rdy` held high an N-word burst takes N*2*BASIC_TICKS clocks of phases.
- R2: Mode code 1 gives matched cycles of address, wait (both strobes low, `busy` high) and data, each MATCH_TICKS clocks long; mode code 2 is the same without the wait phase.
- R3: With `wide`=1 each beat moves 4 bytes and `bus_dat` equals `wdata[31:0]`; with `wide`=0 each beat moves 2 bytes and `bus_dat` equals `wdata[15:0]` zero-extended. Outside data phases `bus_dat` is 0.
- R4: Mode code 3 (32- or 16-bit streaming) drives one address phase of BASIC_TICKS clocks at the start of the burst, then only data beats of STREAM_TICKS clocks each, with `adr_strobe` low until the burst ends.
- R5: Mode codes 4 and 5 (64-bit streaming) move 8 bytes per beat, and during beats `bus_adr` carries `wdata[63:32]`; code 4 beats last STREAM_TICKS clocks and code 5 beats last FAST_TICKS clocks. Outside address phases and 64-bit beats `bus_adr` is 0.
- R6: A streaming code with `tgt_stream`=0, or code 4 or 5 with `dual_path`=0, runs as basic cycles at the width given by `wide`.
- R7: A data phase or beat stays on its last tick until `rdy` is high; `take` is high for exactly the clocks in which a beat is accepted.
- R8: `done` is a one-clock pulse in the clock after the final beat is accepted, and `busy` is low in that same clock.
- R9: `dbg_addr` equals the start address plus the number of bytes already accepted, and it changes only when a beat is accepted.
- R10: While `busy` is high, `start` is ignored. Mode, width and capability inputs are latched when a burst starts. A start with a word count of 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a burst (sampled while idle) |
| start_addr | input | AW | Byte address of the first word |
| word_count | input | CW | Number of beats in the burst |
| mode | input | 3 | Cycle kind: 0 basic, 1 matched with wait, 2 matched without wait, 3 streaming, 4 64-bit streaming, 5 fast 64-bit streaming |
| wide | input | 1 | 1 = 32-bit beats, 0 = 16-bit beats |
| tgt_stream | input | 1 | Target is able to stream |
| dual_path | input | 1 | Configuration is able to run 64-bit streaming |
| rdy | input | 1 | Target ready to accept the current beat |
| wdata | input | 2*AW | Current local word (upper half used only by 64-bit beats) |
| busy | output | 1 | Burst in progress |
| adr_strobe | output | 1 | Address phase |
| dat_strobe | output | 1 | Data phase or streaming beat |
| bus_adr | output | AW | Address lines (upper data in 64-bit beats) |
| bus_dat | output | AW | Data lines |
| take | output | 1 | Current word accepted by the target |
| done | output | 1 | Burst finished (one-clock pulse) |
| dbg_addr | output | AW | Internal address counter |

## Verification
The assertions assume that `rdy` is a level input that is meaningful only on the last tick of a data phase. They also assume that the parameters give every phase a length of at least one clock. The bench drives `rdy` either constantly high, for the timing checks, or with a random level every clock. All inputs change just after a rising edge and never at the edge itself. Start requests that arrive during a burst, and with a zero word count, are injected on purpose. This shows that they leave the outputs on the model's path.

// File: rtl/bus_xfer_seq.sv
module bus_xfer_seq #(
  parameter int AW           = 32,
  parameter int CW           = 16,
  parameter int TW           = 4,
  parameter int BASIC_TICKS  = 2,
  parameter int MATCH_TICKS  = 1,
  parameter int STREAM_TICKS = 2,
  parameter int FAST_TICKS   = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [AW-1:0]   start_addr,
  input  logic [CW-1:0]   word_count,
  input  logic [2:0]      mode,
  input  logic            wide,
  input  logic            tgt_stream,
  input  logic            dual_path,
  input  logic            rdy,
  input  logic [2*AW-1:0] wdata,
  output logic            busy,
  output logic            adr_strobe,
  output logic            dat_strobe,
  output logic [AW-1:0]   bus_adr,
  output logic [AW-1:0]   bus_dat,
  output logic            take,
  output logic            done,
  output logic [AW-1:0]   dbg_addr
);
  localparam logic [TW-1:0] B_LAST = TW'(BASIC_TICKS - 1);
  localparam logic [TW-1:0] M_LAST = TW'(MATCH_TICKS - 1);
  localparam logic [TW-1:0] S_LAST = TW'(STREAM_TICKS - 1);
  localparam logic [TW-1:0] F_LAST = TW'(FAST_TICKS - 1);

  typedef enum logic [2:0] {S_IDLE, S_ADR, S_WAIT, S_DAT, S_BEAT} st_t;
  typedef enum logic [1:0] {K_BASIC, K_MWAIT, K_MNOW, K_STRM} kind_t;

  st_t           state;
  kind_t         kind, kind_in;
  logic          w64, fast, wide_q;
  logic [TW-1:0] cnt;
  logic [CW-1:0] left;
  logic [AW-1:0] addr;

  logic stream_req, big, stream_ok;
  assign stream_req = (mode == 3'd3) || big;
  assign big        = (mode == 3'd4) || (mode == 3'd5);
  assign stream_ok  = tgt_stream && (!big || dual_path);
  assign kind_in    = (mode == 3'd1) ? K_MWAIT :
                      (mode == 3'd2) ? K_MNOW  :
                      (stream_req && stream_ok) ? K_STRM : K_BASIC;

  logic          matched;
  logic [TW-1:0] phase_len, beat_len;
  logic [AW-1:0] step;
  assign matched   = (kind == K_MWAIT) || (kind == K_MNOW);
  assign phase_len = matched ? M_LAST : B_LAST;
  assign beat_len  = fast ? F_LAST : S_LAST;
  assign step      = w64 ? AW'(8) : wide_q ? AW'(4) : AW'(2);

  assign busy       = state != S_IDLE;
  assign adr_strobe = state == S_ADR;
  assign dat_strobe = (state == S_DAT) || (state == S_BEAT);
  assign take       = dat_strobe && cnt == '0 && rdy;
  assign dbg_addr   = addr;
  assign bus_adr    = adr_strobe ? addr :
                      (state == S_BEAT && w64) ? wdata[2*AW-1:AW] : '0;
  assign bus_dat    = !dat_strobe ? '0 :
                      (w64 || wide_q) ? wdata[AW-1:0] : AW'(wdata[15:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      kind   <= K_BASIC;
      w64    <= 1'b0;
      fast   <= 1'b0;
      wide_q <= 1'b0;
      cnt    <= '0;
      left   <= '0;
      addr   <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start && word_count != '0) begin
          kind   <= kind_in;
          w64    <= big && stream_ok;
          fast   <= (mode == 3'd5) && stream_ok;
          wide_q <= wide;
          addr   <= start_addr;
          left   <= word_count;
          cnt    <= (kind_in == K_MWAIT || kind_in == K_MNOW) ? M_LAST : B_LAST;
          state  <= S_ADR;
        end
        S_ADR:
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (kind == K_MWAIT) begin state <= S_WAIT; cnt <= M_LAST;    end
          else if (kind == K_STRM)  begin state <= S_BEAT; cnt <= beat_len;  end
          else                      begin state <= S_DAT;  cnt <= phase_len; end
        S_WAIT:
          if (cnt != '0) cnt <= cnt - 1'b1;
          else begin state <= S_DAT; cnt <= M_LAST; end
        S_DAT, S_BEAT:
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (rdy) begin
            addr <= addr + step;
            left <= left - 1'b1;
            if (left == CW'(1)) begin
              state <= S_IDLE;
              done  <= 1'b1;
            end else if (state == S_DAT) begin
              state <= S_ADR;
              cnt   <= phase_len;
            end else begin
              cnt <= beat_len;
            end
          end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_phase_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({adr_strobe, dat_strobe}));
  assert_no_readdr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BEAT) |=> !adr_strobe);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_strobe && !rdy) |=> $stable(dbg_addr) && dat_strobe);
  assert_done_after_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(take));
  assert_addr_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> dbg_addr == $past(dbg_addr) + $past(step));
  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(kind) && $stable(wide_q) && $stable(w64));
endmodule

// File: tb/tb_bus_xfer_seq.sv
module tb_bus_xfer_seq;
  localparam int CLK_PERIOD = 10;
  localparam int BT = 2, MT = 1, ST = 2, FT = 1;

  logic clk = 0, rst_n = 0;
  logic start = 0, wide = 1, tgt_stream = 0, dual_path = 0, rdy = 1;
  logic [31:0] start_addr = 0;
  logic [15:0] word_count = 0;
  logic [2:0]  mode = 0;
  logic [63:0] wdata = 0;
  logic busy, adr_strobe, dat_strobe, take, done;
  logic [31:0] bus_adr, bus_dat, dbg_addr;

  bus_xfer_seq #(.BASIC_TICKS(BT), .MATCH_TICKS(MT), .STREAM_TICKS(ST), .FAST_TICKS(FT)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr), .word_count(word_count),
    .mode(mode), .wide(wide), .tgt_stream(tgt_stream), .dual_path(dual_path), .rdy(rdy),
    .wdata(wdata), .busy(busy), .adr_strobe(adr_strobe), .dat_strobe(dat_strobe),
    .bus_adr(bus_adr), .bus_dat(bus_dat), .take(take), .done(done), .dbg_addr(dbg_addr));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit rand_rdy = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: phase 0 idle, 1 address, 2 wait, 3 data, 4 beat
  int m_ph, m_cnt, m_left, m_k;
  bit m64, mfast, mwide, m_done;
  logic [31:0] m_addr;

  function automatic int plen();
    return (m_k == 1 || m_k == 2) ? MT : BT;
  endfunction
  function automatic int blen();
    return mfast ? FT : ST;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph <= 0; m_cnt <= 0; m_left <= 0; m_k <= 0; m64 <= 0; mfast <= 0; mwide <= 0;
      m_done <= 0; m_addr <= 0;
    end else begin
      m_done <= 0;
      if (m_ph == 0) begin
        if (start && word_count != 0) begin
          bit sreq, b, ok;
          int k;
          b = (mode == 4 || mode == 5);
          sreq = (mode == 3) || b;
          ok = tgt_stream && (!b || dual_path);
          k = (mode == 1) ? 1 : (mode == 2) ? 2 : (sreq && ok) ? 3 : 0;
          m_k <= k; m64 <= b && ok; mfast <= (mode == 5) && ok; mwide <= wide;
          m_addr <= start_addr; m_left <= word_count; m_ph <= 1;
          m_cnt <= ((k == 1 || k == 2) ? MT : BT) - 1;
        end
      end else if (m_cnt > 0) begin
        m_cnt <= m_cnt - 1;
      end else if (m_ph == 1) begin
        if (m_k == 1) begin m_ph <= 2; m_cnt <= MT - 1; end
        else if (m_k == 3) begin m_ph <= 4; m_cnt <= blen() - 1; end
        else begin m_ph <= 3; m_cnt <= plen() - 1; end
      end else if (m_ph == 2) begin
        m_ph <= 3; m_cnt <= MT - 1;
      end else if (rdy) begin
        m_addr <= m_addr + (m64 ? 8 : mwide ? 4 : 2);
        m_left <= m_left - 1;
        if (m_left == 1) begin m_ph <= 0; m_done <= 1; end
        else if (m_ph == 3) begin m_ph <= 1; m_cnt <= plen() - 1; end
        else m_cnt <= blen() - 1;
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    bit eds, etk;
    logic [31:0] ea, ed;
    eds = (m_ph == 3 || m_ph == 4);
    etk = eds && m_cnt == 0 && rdy;
    ea = (m_ph == 1) ? m_addr : (m_ph == 4 && m64) ? wdata[63:32] : 32'h0;
    ed = !eds ? 32'h0 : (m64 || mwide) ? wdata[31:0] : {16'h0, wdata[15:0]};
    chk(adr_strobe == (m_ph == 1), "R1 adr_strobe", adr_strobe, m_ph == 1);
    chk(busy == (m_ph != 0), "R2 busy", busy, m_ph != 0);
    chk(dat_strobe == eds, "R7 dat_strobe", dat_strobe, eds);
    chk(take == etk, "R7 take", take, etk);
    chk(bus_adr == ea, "R5 bus_adr", bus_adr, ea);
    chk(bus_dat == ed, "R3 bus_dat", bus_dat, ed);
    chk(done == m_done, "R8 done", done, m_done);
    chk(dbg_addr == m_addr, "R9 dbg_addr", dbg_addr, m_addr);
  end

  initial forever begin
    @(posedge clk); #1;
    wdata = {$urandom, $urandom};
    rdy = rand_rdy ? 1'($urandom_range(0, 1)) : 1'b1;
  end

  // run one burst; exp_len < 0 skips the timing check; glitch_at > 0 pulses start mid-burst
  task automatic run(input string tag, input logic [31:0] a, input int n, input logic [2:0] md,
                     input bit wd, input bit ts, input bit dp, input int step,
                     input int exp_len, input int glitch_at);
    int cyc = 0;
    @(posedge clk); #1;
    start_addr = a; word_count = 16'(n); mode = md; wide = wd; tgt_stream = ts; dual_path = dp;
    start = 1;
    @(posedge clk); #1;
    start = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc == glitch_at) begin
        #1; start = 1; mode = 3'd0; wide = ~wd; start_addr = 32'hDEAD0000;
        @(posedge clk); #1; start = 0;
      end
      if (done) break;
    end
    if (exp_len >= 0) chk(cyc == exp_len, {tag, " burst length"}, cyc, exp_len);
    chk(dbg_addr == a + 32'(n * step), {tag, " final address R9"}, dbg_addr, a + 32'(n * step));
    @(negedge clk);
    chk(!done && !busy, {tag, " R8 done single pulse"}, {done, busy}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    chk(busy == 0 && adr_strobe == 0 && dat_strobe == 0 && done == 0 && bus_adr == 0,
        "R8 reset state", {busy, adr_strobe, dat_strobe, done}, 0);
    rst_n = 1;
    run("R1 basic32",        32'h1000, 3, 3'd0, 1, 0, 0, 4, 3*2*BT + 1, 0);
    run("R3 basic16",        32'h2002, 4, 3'd0, 0, 0, 0, 2, 4*2*BT + 1, 0);
    run("R2 matched wait",   32'h3000, 3, 3'd1, 1, 0, 0, 4, 3*3*MT + 1, 0);
    run("R2 matched nowait", 32'h3100, 3, 3'd2, 1, 0, 0, 4, 3*2*MT + 1, 0);
    run("R4 stream32",       32'h4000, 5, 3'd3, 1, 1, 0, 4, BT + 5*ST + 1, 0);
    run("R4 stream16",       32'h4100, 4, 3'd3, 0, 1, 0, 2, BT + 4*ST + 1, 0);
    run("R5 stream64",       32'h5000, 4, 3'd4, 1, 1, 1, 8, BT + 4*ST + 1, 0);
    run("R5 stream64 fast",  32'h5800, 6, 3'd5, 0, 1, 1, 8, BT + 6*FT + 1, 0);
    run("R6 no tgt stream",  32'h6000, 2, 3'd3, 1, 0, 1, 4, 2*2*BT + 1, 0);
    run("R6 no dual path",   32'h6100, 2, 3'd4, 0, 1, 0, 2, 2*2*BT + 1, 0);
    run("R6 code 7",         32'h6200, 2, 3'd7, 1, 1, 1, 4, 2*2*BT + 1, 0);
    run("R10 start busy",    32'h7000, 4, 3'd3, 1, 1, 0, 4, BT + 4*ST + 1, 3);
    @(posedge clk); #1;
    word_count = 0; mode = 3'd0; start = 1;
    @(posedge clk); #1; start = 0;
    @(negedge clk);
    chk(!busy && !adr_strobe, "R10 zero count ignored", busy, 0);
    rand_rdy = 1;
    run("R7 basic rand rdy",  32'h8000, 5, 3'd0, 1, 0, 0, 4, -1, 0);
    run("R7 matched rand",    32'h8100, 4, 3'd1, 0, 0, 0, 2, -1, 0);
    run("R7 stream64 rand",   32'h8200, 8, 3'd5, 1, 1, 1, 8, -1, 0);
    rand_rdy = 0;
    repeat (3) @(posedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule